// File: doc/BRIEF.md
# Banked Flash and I/O Slot Decoder

This block is the glue logic that sits on an 8-bit processor bus with a 16-bit address, the phase-two bus clock, a read/not-write strobe and the low four data lines. It does three jobs at once. It drives an active-low enable for an 8 KB flash window at the bottom of the upper half of the address space. It keeps a 4-bit bank number that drives the flash device's four upper address lines, so the window can reach sixteen 8 KB banks. It also decodes a 256-byte I/O page into eight 32-byte slots, each with its own active-low select that is only active while the bus clock is high.

Software chooses a flash bank by storing a value from 0 to 15 to the top slot of the I/O page. The processor's data bus is not settled when the bus clock rises, so the bank number is captured on the falling edge of the bus clock, when the data is valid. The bank register cannot be read back. All enables and selects are combinational decodes of the bus, so they follow the address without any added cycle.

Top module: `bank_flash_decoder`

## Requirements
- R1: `flash_ce_n` is 0 exactly when address bits 15..13 equal 3'b100 (0x8000 to 0x9FFF), and it does not depend on the bus clock level.
- R2: The bank register responds to any address whose bits 15..5 equal 11'h5FF (0xBFE0 to 0xBFFF). Address bits 4..0 are ignored.
- R3: On a write (`bus_rnw` = 0) to the bank slot, `flash_bank` takes `bus_data` as it stands at the falling edge of `phi2`. Values seen earlier in the high phase are not kept.
- R4: A read (`bus_rnw` = 1) of the bank slot, or a write to any other address, leaves `flash_bank` unchanged.
- R5: `flash_bank` holds its value over any number of bus cycles until the next bank write, and covers the whole range 0 to 15.
- R6: While `phi2` is 1 and address bits 15..8 equal 8'hBF, `io_sel_n[k]` is 0 for k = address bits 7..5 and the other seven selects are 1.
- R7: While `phi2` is 0, or when address bits 15..8 are not 8'hBF, all of `io_sel_n` are 1.
- R8: The slot-7 select (`io_sel_n[7]`) still goes to 0 during an access to the bank slot, reads and writes alike.
- R9: `rst` at 1 on a falling edge of `phi2` sets `flash_bank` to 0.
- R10: `flash_ce_n` at 0 and any `io_sel_n` bit at 0 never happen together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Phase-two bus clock. The bank register captures on its falling edge. |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge of phi2 |
| bus_addr | input | 16 | Processor address bus |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_data | input | 4 | Low nibble of the data bus |
| flash_ce_n | output | 1 | Active-low flash chip enable |
| flash_bank | output | 4 | Bank number driven onto flash address lines 16..13 |
| io_sel_n | output | 8 | Active-low I/O slot selects, qualified by phi2 high |

## Verification
Directed cycles probe each edge of the flash window: 0x8000 and 0x9FFF enable it, while 0x7FFF and 0xA000 do not. All eight I/O slots are visited in both clock phases, and one access falls just outside the I/O page, so a fault in the page compare shows up apart from a fault in the phi2 qualification. Bank writes change the data in the middle of the high phase, which tells a falling-edge capture apart from a rising-edge or early one. Accesses to the bank address with the wrong direction, with a neighbouring slot, or with A14 or A15 flipped must leave the bank unchanged. A seeded random run aimed mostly at the I/O page then mixes all of these cases against the bench's own model.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  // Default bus geometry shared by the decoder modules.
  localparam int unsigned BUS_ADDR_W = 16;
  localparam int unsigned BUS_BANK_W = 4;
  localparam int unsigned BUS_SEL_N  = 8;
  localparam int unsigned BUS_PAGE_W = 8;
  localparam int unsigned BUS_TAG_W  = 3;
endpackage

// File: rtl/flash_window.sv
module flash_window #(
  parameter int unsigned TAG_W = bfd_pkg::BUS_TAG_W,
  parameter logic [TAG_W-1:0] TAG = 3'b100
) (
  input  logic [TAG_W-1:0] addr_tag,
  output logic             ce_n
);
  // Window enable: the upper address bits select the 8 KB flash window.
  always_comb ce_n = (addr_tag != TAG);
endmodule

// File: rtl/io_slot_decode.sv
module io_slot_decode #(
  parameter int unsigned PAGE_W = bfd_pkg::BUS_PAGE_W,
  parameter logic [PAGE_W-1:0] PAGE = 8'hBF,
  parameter int unsigned SEL_N  = bfd_pkg::BUS_SEL_N,
  localparam int unsigned SEL_W = $clog2(SEL_N)
) (
  input  logic              phi2,
  input  logic              rst,
  input  logic [PAGE_W-1:0] page,
  input  logic [SEL_W-1:0]  slot,
  output logic              page_hit,
  output logic [SEL_N-1:0]  sel_n
);
  logic strobe;

  always_comb page_hit = (page == PAGE);
  // Selects only open during the high phase of the bus clock.
  always_comb strobe = page_hit && phi2;

  for (genvar k = 0; k < SEL_N; k++) begin : g_slot
    assign sel_n[k] = !(strobe && (slot == SEL_W'(k)));
  end

  // R7: the whole low phase ends with every select idle.
  assert_idle_low_phase_R7: assert property (@(posedge phi2) disable iff (rst)
    sel_n == '1);
  // R6: at the end of the high phase exactly one select is active on a page hit, none otherwise.
  assert_one_select_R6: assert property (@(negedge phi2) disable iff (rst)
    $countones(~sel_n) == (page_hit ? 1 : 0));
endmodule

// File: rtl/bank_reg.sv
module bank_reg #(
  parameter int unsigned BANK_W = bfd_pkg::BUS_BANK_W
) (
  input  logic              phi2,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] din,
  output logic [BANK_W-1:0] bank
);
  // Captured on the falling edge, when the write data has settled.
  always_ff @(negedge phi2) begin
    if (rst)        bank <= '0;
    else if (wr_en) bank <= din;
  end

  // R3: a qualified write leaves the data present at that falling edge.
  assert_capture_at_fall_R3: assert property (@(negedge phi2) disable iff (rst)
    wr_en |=> (bank == $past(din)));
  // R4: with no qualified write the bank does not move.
  assert_hold_without_write_R4: assert property (@(negedge phi2) disable iff (rst)
    !wr_en |=> $stable(bank));
  // R9: reset at a falling edge clears the bank.
  assert_reset_clears_R9: assert property (@(negedge phi2)
    rst |=> (bank == '0));
endmodule

// File: rtl/bank_flash_decoder.sv
module bank_flash_decoder #(
  parameter int unsigned ADDR_W = bfd_pkg::BUS_ADDR_W,
  parameter int unsigned BANK_W = bfd_pkg::BUS_BANK_W,
  parameter int unsigned SEL_N  = bfd_pkg::BUS_SEL_N,
  parameter int unsigned PAGE_W = bfd_pkg::BUS_PAGE_W,
  parameter int unsigned TAG_W  = bfd_pkg::BUS_TAG_W,
  parameter logic [PAGE_W-1:0] IO_PAGE   = 8'hBF,
  parameter logic [TAG_W-1:0]  FLASH_TAG = 3'b100,
  parameter int unsigned BANK_SLOT = 7
) (
  input  logic              phi2,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rnw,
  input  logic [BANK_W-1:0] bus_data,
  output logic              flash_ce_n,
  output logic [BANK_W-1:0] flash_bank,
  output logic [SEL_N-1:0]  io_sel_n
);
  localparam int unsigned SEL_W    = $clog2(SEL_N);
  localparam int unsigned SLOT_LSB = ADDR_W - PAGE_W - SEL_W;

  logic [SEL_W-1:0] slot;
  logic             page_hit;
  logic             bank_wr;
  logic             unused_low_addr;

  always_comb slot = bus_addr[ADDR_W-PAGE_W-1 -: SEL_W];
  always_comb unused_low_addr = ^bus_addr[SLOT_LSB-1:0];

  flash_window #(.TAG_W(TAG_W), .TAG(FLASH_TAG)) u_window (
    .addr_tag (bus_addr[ADDR_W-1 -: TAG_W]),
    .ce_n     (flash_ce_n)
  );

  io_slot_decode #(.PAGE_W(PAGE_W), .PAGE(IO_PAGE), .SEL_N(SEL_N)) u_io (
    .phi2     (phi2),
    .rst      (rst),
    .page     (bus_addr[ADDR_W-1 -: PAGE_W]),
    .slot     (slot),
    .page_hit (page_hit),
    .sel_n    (io_sel_n)
  );

  // Bank write: the top I/O slot addressed with a write strobe (R2, R4).
  always_comb bank_wr = page_hit && (slot == SEL_W'(BANK_SLOT)) && !bus_rnw;

  bank_reg #(.BANK_W(BANK_W)) u_bank (
    .phi2  (phi2),
    .rst   (rst),
    .wr_en (bank_wr),
    .din   (bus_data),
    .bank  (flash_bank)
  );

  // R10: flash window and I/O page never select together.
  assert_no_overlap_R10: assert property (@(negedge phi2) disable iff (rst)
    !flash_ce_n |-> (io_sel_n == '1));
  // R8: a bank write still strobes the shared top slot select.
  assert_shared_slot_R8: assert property (@(negedge phi2) disable iff (rst)
    bank_wr |-> !io_sel_n[BANK_SLOT]);
endmodule

// File: tb/bank_flash_decoder_test.sv
module bank_flash_decoder_test;
  localparam int CLK_PERIOD = 20;

  logic        phi2 = 1'b0;
  logic        rst  = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_rnw  = 1'b1;
  logic [3:0]  bus_data = 4'h0;
  logic        flash_ce_n;
  logic [3:0]  flash_bank;
  logic [7:0]  io_sel_n;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_bank = 4'h0;

  bank_flash_decoder uut (
    .phi2(phi2), .rst(rst), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_data(bus_data), .flash_ce_n(flash_ce_n), .flash_bank(flash_bank),
    .io_sel_n(io_sel_n)
  );

  always #(CLK_PERIOD/2) phi2 = ~phi2;

  function automatic logic exp_ce_n(input logic [15:0] a);
    return !(a[15:13] == 3'b100);
  endfunction

  function automatic logic [7:0] exp_sel_n(input logic [15:0] a, input logic hi);
    if (hi && a[15:8] == 8'hBF) return ~(8'h01 << a[7:5]);
    return 8'hFF;
  endfunction

  function automatic logic is_bank_addr(input logic [15:0] a);
    return a[15:5] == 11'h5FF;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: address in the low phase, data changed mid high phase,
  // capture at the falling edge, then the bus returns to an idle read.
  task automatic bus_cycle(input logic [15:0] a, input logic rnw,
                           input logic [3:0] d_early, input logic [3:0] d_late,
                           input string btag);
    @(negedge phi2);
    #2;
    bus_addr = a; bus_rnw = rnw; bus_data = d_early;
    #1;
    chk(io_sel_n == 8'hFF, "R7 low phase", {8'h0, io_sel_n}, 16'h00FF);
    chk(flash_ce_n == exp_ce_n(a), "R1 low phase", {15'h0, flash_ce_n}, {15'h0, exp_ce_n(a)});
    @(posedge phi2);
    #3;
    bus_data = d_late;
    #2;
    chk(io_sel_n == exp_sel_n(a, 1'b1), is_bank_addr(a) ? "R8 shared slot" : "R6 high phase",
        {8'h0, io_sel_n}, {8'h0, exp_sel_n(a, 1'b1)});
    chk(flash_ce_n == exp_ce_n(a), "R1 high phase", {15'h0, flash_ce_n}, {15'h0, exp_ce_n(a)});
    chk(!(flash_ce_n == 1'b0 && io_sel_n != 8'hFF), "R10 overlap",
        {7'h0, flash_ce_n, io_sel_n}, {7'h0, flash_ce_n, 8'hFF});
    if (is_bank_addr(a) && !rnw) model_bank = d_late;
    @(negedge phi2);
    #1;
    chk(flash_bank == model_bank, btag, {12'h0, flash_bank}, {12'h0, model_bank});
    bus_addr = 16'h0000; bus_rnw = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005_EED5));
    repeat (2) @(negedge phi2);
    #2 rst = 1'b0;
    #1 chk(flash_bank == 4'h0, "R9 reset value", {12'h0, flash_bank}, 16'h0);

    // R1 window edges
    bus_cycle(16'h8000, 1'b1, 4'h0, 4'h0, "R5 hold");
    bus_cycle(16'h9FFF, 1'b1, 4'h0, 4'h0, "R5 hold");
    bus_cycle(16'hA000, 1'b1, 4'h0, 4'h0, "R5 hold");
    bus_cycle(16'h7FFF, 1'b1, 4'h0, 4'h0, "R5 hold");
    // R6/R7 every slot, both phases
    for (int k = 0; k < 8; k++)
      bus_cycle(16'hBF00 + 16'(k * 32), 1'b1, 4'h0, 4'h0, "R4 read no change");
    bus_cycle(16'hBE20, 1'b1, 4'h0, 4'h0, "R7 page miss");
    // R3 late data wins
    bus_cycle(16'hBFE0, 1'b0, 4'h5, 4'hA, "R3 capture at fall");
    // R2 low bits ignored
    bus_cycle(16'hBFFF, 1'b0, 4'hC, 4'h3, "R2 low bits ignored");
    // R4 no-effect cases
    bus_cycle(16'hBFE0, 1'b1, 4'h7, 4'h7, "R4 read no change");
    bus_cycle(16'hBFC0, 1'b0, 4'h6, 4'h6, "R4 neighbour slot");
    bus_cycle(16'hFFE0, 1'b0, 4'h9, 4'h9, "R4 A14 set");
    bus_cycle(16'h3FE0, 1'b0, 4'h9, 4'h9, "R4 A15 clear");
    // R5 range ends and hold
    bus_cycle(16'hBFE0, 1'b0, 4'h0, 4'hF, "R5 bank 15");
    bus_cycle(16'h9000, 1'b1, 4'h0, 4'h0, "R5 hold");
    bus_cycle(16'hBFE0, 1'b0, 4'hF, 4'h0, "R5 bank 0");
    bus_cycle(16'hBFE4, 1'b0, 4'h0, 4'h9, "R3 capture at fall");

    // R9 reset mid-run
    @(negedge phi2);
    #2 rst = 1'b1;
    @(negedge phi2);
    #1 chk(flash_bank == 4'h0, "R9 reset clears", {12'h0, flash_bank}, 16'h0);
    model_bank = 4'h0;
    #1 rst = 1'b0;

    // Random traffic, mostly aimed at the I/O page
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic        rnw;
      logic [3:0]  d0, d1;
      a   = 16'($urandom);
      if ($urandom_range(0, 3) != 0) a[15:8] = 8'hBF;
      if ($urandom_range(0, 7) == 0) a[15:13] = 3'b100;
      rnw = 1'($urandom);
      d0  = 4'($urandom);
      d1  = 4'($urandom);
      bus_cycle(a, rnw, d0, d1, (is_bank_addr(a) && !rnw) ? "R3 random write" : "R4 random hold");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule